// File: doc/BRIEF.md
# Interrupt Prioritization and Trap Injection

This block sits between the interrupt sources of a pipelined 16-bit controller and its decode stage. Each source has a sticky request flag. Once a flag is set, a prioritization round picks the best eligible source. In the next cycle a trap is placed into the decode stage in place of the instruction that followed the interrupted one (N). The same cycle clears the winner's flag. The cycle after that pushes the saved processor state and fetches the first handler instruction from the winner's vector address.

Instructions younger than N are discarded, and the saved instruction pointer points at N+1 so they run again after the handler returns. The response is stretched by a per-instruction penalty computed from a short description of instruction N, and by a pipeline hold that keeps the trap out of decode while older instructions drain. Only one trap sequence can be in flight at a time.

Top module: `irq_trap_inject`

## Requirements
- R1: A high `irq_req[i]` at a clock edge sets flag `i`, visible on `pend_flags[i]` after that edge. A set flag stays set until its own trap is injected. A request in the same cycle as that source's clear leaves the flag set.
- R2: A source is eligible only when its flag is set, `src_en[i]` is 1, `glb_ie` is 1 and its level (`src_level[i*4+3:i*4]`) is strictly greater than `cpu_level`. An ineligible pending source is never injected and its flag remains set.
- R3: Among eligible sources the highest level wins. Equal levels go to the lowest source index.
- R4: With no penalty and no hold, a request sampled in cycle c0 gives `inj_valid` in cycle c0+2 and `vec_fetch` in cycle c0+3. `vec_fetch` always follows `inj_valid` by exactly one cycle.
- R5: The penalty, sampled in the arbitration cycle, delays injection by one cycle for each of: `req_first_state`, `n_hold_pairs[0]` (N-2/N-1 hold), `n_hold_pairs[1]` (N-1/N hold) and `n_psw_sp_wr`. It adds two cycles for each of `n_long_op` (call, return, trap or code-memory operand) and `n_flag_read` (N reads the status word after N-1 changed flags).
- R6: While `pipe_hold` is 1 in the injection state, no trap is injected. Injection happens in the first such cycle with `pipe_hold` at 0.
- R7: The injection cycle clears only the winner's flag, and `inj_src` names the winner.
- R8: In the `vec_fetch` cycle, `save_strobe` is 1. `save_psw` and `save_ip` carry the `psw_in` and `next_ip` values from the injection cycle. `save_csp_strobe` is 1 with `save_csp` (the `csp_in` of that cycle) only when `seg_mode` was 1 in that cycle.
- R9: `vec_addr` equals the winning source index times 4, presented with `vec_fetch`.
- R10: From arbitration until the cycle after `vec_fetch`, no new winner is taken. The next round runs in the cycle after `vec_fetch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NSRC | Per-source request pulses |
| src_en | input | NSRC | Per-source enable |
| src_level | input | NSRC*PRIO_W | Per-source priority level, source i at bits i*PRIO_W upward |
| glb_ie | input | 1 | Global interrupt enable |
| cpu_level | input | PRIO_W | Current CPU priority level |
| req_first_state | input | 1 | Flag set in the first state of an instruction cycle |
| n_hold_pairs | input | 2 | Hold between N-2/N-1 (bit 0) and N-1/N (bit 1) |
| n_psw_sp_wr | input | 1 | N writes the status word or stack pointer |
| n_long_op | input | 1 | N is call/return/trap or reads code memory |
| n_flag_read | input | 1 | N reads status word after N-1 changed flags |
| pipe_hold | input | 1 | Older instructions not yet finished |
| psw_in | input | 16 | Current status word |
| next_ip | input | 16 | Address of instruction N+1 |
| csp_in | input | 8 | Current code segment pointer |
| seg_mode | input | 1 | Segmented mode enabled |
| pend_flags | output | NSRC | Pending request flags |
| inj_valid | output | 1 | Trap replaces N+1 in decode; younger instructions discarded |
| inj_src | output | $clog2(NSRC) | Source of the injected trap |
| save_strobe | output | 1 | Push status word and instruction pointer |
| save_psw | output | 16 | Status word to push |
| save_ip | output | 16 | Instruction pointer to push |
| save_csp_strobe | output | 1 | Push code segment pointer |
| save_csp | output | 8 | Code segment pointer to push |
| vec_fetch | output | 1 | Fetch first handler instruction |
| vec_addr | output | ADDR_W | Handler vector address |

## Verification
On every cycle, the embedded properties cover flag behaviour: setting on request, holding while pending, and clearing only on the winner's injection. They also confirm that an arbitration result belongs to a pending, enabled source, that fetch follows injection by one cycle, that the winner stays frozen during a sequence, that vectors are word aligned and that the pushed pointer is the one presented at injection. The bench's scenarios are needed to show the response latencies for each penalty mix and hold length, priority and tie ordering, and the strict level comparison. They also show masking by the enable bits, the segmented-mode push choice, and the ordering of requests that arrive during a sequence.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int WORD_W = 16;
    localparam int CSP_W  = 8;
    localparam int PEN_W  = 4;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_WAIT = 2'd1,
        S_INJ  = 2'd2,
        S_SAVE = 2'd3
    } seq_state_t;

    // Description of the instruction being interrupted (N)
    typedef struct packed {
        logic       first_state;
        logic [1:0] hold_pairs;
        logic       psw_sp_wr;
        logic       long_op;
        logic       flag_read;
    } inst_cost_t;

    // State captured at the injection cycle and pushed one cycle later
    typedef struct packed {
        logic [WORD_W-1:0] psw;
        logic [WORD_W-1:0] ip;
        logic [CSP_W-1:0]  csp;
        logic              seg;
    } save_rec_t;

    // Extra response cycles caused by instruction N
    function automatic logic [PEN_W-1:0] resp_penalty(inst_cost_t c);
        logic [PEN_W-1:0] sum;
        sum = PEN_W'(c.first_state)
            + PEN_W'(c.hold_pairs[0])
            + PEN_W'(c.hold_pairs[1])
            + PEN_W'(c.psw_sp_wr)
            + (PEN_W'(c.long_op) << 1)
            + (PEN_W'(c.flag_read) << 1);
        return sum;
    endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int NSRC  = 8,
    parameter int IDX_W = $clog2(NSRC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  set_req,
    input  logic             clr_vld,
    input  logic [IDX_W-1:0] clr_idx,
    output logic [NSRC-1:0]  flags
);

    logic [NSRC-1:0] clr_mask;

    always_comb begin
        clr_mask = '0;
        if (clr_vld) clr_mask[clr_idx] = 1'b1;
    end

    // Set has priority over clear for the same source
    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~clr_mask) | set_req;
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_chk
        p_set_r1: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(set_req[i])) |-> flags[i]);

        p_keep_r1: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(flags[i]) &&
             !($past(clr_vld) && ($past(clr_idx) == IDX_W'(i)))) |-> flags[i]);

        p_clear_r7: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(clr_vld) && ($past(clr_idx) == IDX_W'(i)) &&
             !$past(set_req[i])) |-> !flags[i]);
    end

endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter #(
    parameter int NSRC   = 8,
    parameter int PRIO_W = 4,
    parameter int IDX_W  = $clog2(NSRC)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NSRC-1:0]        flags,
    input  logic [NSRC-1:0]        src_en,
    input  logic [NSRC*PRIO_W-1:0] src_level,
    input  logic                   glb_ie,
    input  logic [PRIO_W-1:0]      cpu_level,
    output logic                   win_vld,
    output logic [IDX_W-1:0]       win_idx
);

    logic [NSRC-1:0]   elig;
    logic [PRIO_W-1:0] lvl [NSRC];

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign lvl[i]  = src_level[i*PRIO_W +: PRIO_W];
        assign elig[i] = flags[i] && src_en[i] && glb_ie && (lvl[i] > cpu_level);
    end

    // Strict comparison while scanning upward keeps the lowest index on ties
    always_comb begin
        logic [PRIO_W-1:0] best_lvl;
        win_vld  = 1'b0;
        win_idx  = '0;
        best_lvl = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (elig[i] && (!win_vld || lvl[i] > best_lvl)) begin
                win_vld  = 1'b1;
                win_idx  = IDX_W'(i);
                best_lvl = lvl[i];
            end
        end
    end

    p_win_pending_r2: assert property (@(posedge clk) disable iff (rst)
        win_vld |-> (flags[win_idx] && src_en[win_idx] && glb_ie &&
                     (src_level[win_idx*PRIO_W +: PRIO_W] > cpu_level)));

    p_none_when_off_r2: assert property (@(posedge clk) disable iff (rst)
        !glb_ie |-> !win_vld);

endmodule

// File: rtl/irq_trap_seq.sv
module irq_trap_seq
    import irq_pkg::*;
#(
    parameter int NSRC   = 8,
    parameter int ADDR_W = 16,
    parameter int IDX_W  = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              win_vld,
    input  logic [IDX_W-1:0]  win_idx,
    input  inst_cost_t        cost,
    input  logic              pipe_hold,
    input  logic [WORD_W-1:0] psw_in,
    input  logic [WORD_W-1:0] ip_in,
    input  logic [CSP_W-1:0]  csp_in,
    input  logic              seg_mode,
    output logic              inj_valid,
    output logic [IDX_W-1:0]  inj_src,
    output logic              save_strobe,
    output save_rec_t         save_rec,
    output logic              save_csp_strobe,
    output logic              vec_fetch,
    output logic [ADDR_W-1:0] vec_addr
);

    seq_state_t       st;
    logic [PEN_W-1:0] cnt;
    logic [IDX_W-1:0] win_q;
    logic [PEN_W-1:0] pen;

    assign pen = resp_penalty(cost);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            cnt      <= '0;
            win_q    <= '0;
            save_rec <= '0;
        end else begin
            unique case (st)
                S_IDLE: if (win_vld) begin
                    win_q <= win_idx;
                    cnt   <= pen;
                    st    <= (pen == '0) ? S_INJ : S_WAIT;
                end
                S_WAIT: begin
                    cnt <= cnt - PEN_W'(1);
                    if (cnt == PEN_W'(1)) st <= S_INJ;
                end
                S_INJ: if (!pipe_hold) begin
                    save_rec.psw <= psw_in;
                    save_rec.ip  <= ip_in;
                    save_rec.csp <= csp_in;
                    save_rec.seg <= seg_mode;
                    st           <= S_SAVE;
                end
                S_SAVE: st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    assign inj_valid       = (st == S_INJ) && !pipe_hold;
    assign inj_src         = win_q;
    assign vec_fetch       = (st == S_SAVE);
    assign save_strobe     = vec_fetch;
    assign save_csp_strobe = vec_fetch && save_rec.seg;
    assign vec_addr        = ADDR_W'(win_q) << 2;

    p_fetch_follows_r4: assert property (@(posedge clk) disable iff (rst)
        inj_valid |=> vec_fetch);

    p_fetch_needs_inj_r10: assert property (@(posedge clk) disable iff (rst)
        vec_fetch |-> (!$past(rst) && $past(inj_valid)));

    p_win_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        (st != S_IDLE) |=> $stable(win_q));

    p_csp_in_save_r8: assert property (@(posedge clk) disable iff (rst)
        save_csp_strobe |-> save_strobe);

    p_ip_pushed_r8: assert property (@(posedge clk) disable iff (rst)
        vec_fetch |-> (save_rec.ip == $past(ip_in)));

    p_vec_align_r9: assert property (@(posedge clk) disable iff (rst)
        vec_fetch |-> (vec_addr[1:0] == 2'b00));

    p_hold_blocks_r6: assert property (@(posedge clk) disable iff (rst)
        pipe_hold |-> !inj_valid);

endmodule

// File: rtl/irq_trap_inject.sv
module irq_trap_inject
    import irq_pkg::*;
#(
    parameter int NSRC   = 8,
    parameter int PRIO_W = 4,
    parameter int ADDR_W = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NSRC-1:0]           irq_req,
    input  logic [NSRC-1:0]           src_en,
    input  logic [NSRC*PRIO_W-1:0]    src_level,
    input  logic                      glb_ie,
    input  logic [PRIO_W-1:0]         cpu_level,
    input  logic                      req_first_state,
    input  logic [1:0]                n_hold_pairs,
    input  logic                      n_psw_sp_wr,
    input  logic                      n_long_op,
    input  logic                      n_flag_read,
    input  logic                      pipe_hold,
    input  logic [15:0]               psw_in,
    input  logic [15:0]               next_ip,
    input  logic [7:0]                csp_in,
    input  logic                      seg_mode,
    output logic [NSRC-1:0]           pend_flags,
    output logic                      inj_valid,
    output logic [$clog2(NSRC)-1:0]   inj_src,
    output logic                      save_strobe,
    output logic [15:0]               save_psw,
    output logic [15:0]               save_ip,
    output logic                      save_csp_strobe,
    output logic [7:0]                save_csp,
    output logic                      vec_fetch,
    output logic [ADDR_W-1:0]         vec_addr
);

    localparam int IDX_W = $clog2(NSRC);

    logic             win_vld;
    logic [IDX_W-1:0] win_idx;
    inst_cost_t       cost;
    save_rec_t        rec;

    assign cost = '{first_state: req_first_state, hold_pairs: n_hold_pairs,
                    psw_sp_wr: n_psw_sp_wr, long_op: n_long_op,
                    flag_read: n_flag_read};

    irq_flag_bank #(.NSRC(NSRC), .IDX_W(IDX_W)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_req (irq_req),
        .clr_vld (inj_valid),
        .clr_idx (inj_src),
        .flags   (pend_flags)
    );

    irq_prio_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .flags     (pend_flags),
        .src_en    (src_en),
        .src_level (src_level),
        .glb_ie    (glb_ie),
        .cpu_level (cpu_level),
        .win_vld   (win_vld),
        .win_idx   (win_idx)
    );

    irq_trap_seq #(.NSRC(NSRC), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_seq (
        .clk             (clk),
        .rst             (rst),
        .win_vld         (win_vld),
        .win_idx         (win_idx),
        .cost            (cost),
        .pipe_hold       (pipe_hold),
        .psw_in          (psw_in),
        .ip_in           (next_ip),
        .csp_in          (csp_in),
        .seg_mode        (seg_mode),
        .inj_valid       (inj_valid),
        .inj_src         (inj_src),
        .save_strobe     (save_strobe),
        .save_rec        (rec),
        .save_csp_strobe (save_csp_strobe),
        .vec_fetch       (vec_fetch),
        .vec_addr        (vec_addr)
    );

    assign save_psw = rec.psw;
    assign save_ip  = rec.ip;
    assign save_csp = rec.csp;

endmodule

// File: tb/tb_irq_trap_inject.sv
`timescale 1ns/1ps
module tb_irq_trap_inject;

    localparam int NSRC = 8;
    localparam int PW   = 4;
    localparam int AW   = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [NSRC-1:0]    irq_req = '0;
    logic [NSRC-1:0]    src_en = '1;
    logic [NSRC*PW-1:0] src_level = '0;
    logic               glb_ie = 1'b1;
    logic [PW-1:0]      cpu_level = '0;
    logic               req_first_state = 1'b0;
    logic [1:0]         n_hold_pairs = '0;
    logic               n_psw_sp_wr = 1'b0, n_long_op = 1'b0, n_flag_read = 1'b0;
    logic               pipe_hold = 1'b0;
    logic [15:0]        psw_in = '0, next_ip = '0;
    logic [7:0]         csp_in = '0;
    logic               seg_mode = 1'b1;

    logic [NSRC-1:0] pend_flags;
    logic            inj_valid, save_strobe, save_csp_strobe, vec_fetch;
    logic [2:0]      inj_src;
    logic [15:0]     save_psw, save_ip;
    logic [7:0]      save_csp;
    logic [AW-1:0]   vec_addr;

    irq_trap_inject #(.NSRC(NSRC), .PRIO_W(PW), .ADDR_W(AW)) dut (.*);

    int checks = 0, errors = 0, cyc = 0;

    // Behavioural reference state
    bit [NSRC-1:0] m_flag;
    int m_st = 0, m_cnt = 0, m_win = 0;
    int m_psw = 0, m_ip = 0, m_csp = 0, m_seg = 0;

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic int lvl(int i);
        return int'(src_level[i*PW +: PW]);
    endfunction

    task automatic set_lvl(int i, int v);
        src_level[i*PW +: PW] = PW'(v);
    endtask

    function automatic int pick();
        int best = -1;
        for (int i = 0; i < NSRC; i++)
            if (m_flag[i] && src_en[i] && glb_ie && lvl(i) > int'(cpu_level))
                if (best < 0 || lvl(i) > lvl(best)) best = i;
        return best;
    endfunction

    function automatic int penalty();
        return int'(req_first_state) + int'(n_hold_pairs[0]) + int'(n_hold_pairs[1])
             + int'(n_psw_sp_wr) + 2*int'(n_long_op) + 2*int'(n_flag_read);
    endfunction

    task automatic compare();
        bit e_inj, e_fetch;
        e_inj   = (m_st == 2) && !pipe_hold;
        e_fetch = (m_st == 3);
        chk("R1/R7 pend_flags", pend_flags, m_flag);
        chk("R4/R6 inj_valid", inj_valid, e_inj);
        if (e_inj) chk("R7 inj_src", inj_src, m_win);
        chk("R4 vec_fetch", vec_fetch, e_fetch);
        chk("R8 save_strobe", save_strobe, e_fetch);
        chk("R8 save_csp_strobe", save_csp_strobe, e_fetch && m_seg != 0);
        if (e_fetch) begin
            chk("R9 vec_addr", vec_addr, m_win * 4);
            chk("R8 save_psw", save_psw, m_psw);
            chk("R8 save_ip", save_ip, m_ip);
            if (m_seg != 0) chk("R8 save_csp", save_csp, m_csp);
        end
    endtask

    task automatic model_edge();
        bit [NSRC-1:0] clr = '0;
        int p;
        case (m_st)
            0: begin
                p = pick();
                if (p >= 0) begin
                    m_win = p;
                    m_cnt = penalty();
                    m_st  = (m_cnt == 0) ? 2 : 1;
                end
            end
            1: begin m_cnt--; if (m_cnt == 0) m_st = 2; end
            2: if (!pipe_hold) begin
                clr[m_win] = 1'b1;
                m_psw = psw_in; m_ip = next_ip; m_csp = csp_in; m_seg = seg_mode;
                m_st = 3;
            end
            default: m_st = 0;
        endcase
        m_flag = (m_flag & ~clr) | irq_req;
    endtask

    // One cycle: varying datapath inputs, compare, then clock edge
    task automatic tick();
        psw_in  = 16'(16'hA000 + cyc);
        next_ip = 16'(16'h1000 + 2*cyc);
        csp_in  = 8'(cyc) ^ 8'h5A;
        #1 compare();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        cyc++;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    // Pulse a request and count cycles until the vector fetch
    task automatic latency(bit [NSRC-1:0] req, int release_at, output int n);
        pipe_hold = (release_at > 0);
        irq_req = req;
        n = 0;
        tick();
        irq_req = '0;
        n = 1;
        if (n >= release_at) pipe_hold = 1'b0;
        #1;
        while (!vec_fetch && n < 60) begin
            tick();
            n++;
            if (n >= release_at) pipe_hold = 1'b0;
            #1;
        end
        pipe_hold = 1'b0;
    endtask

    task automatic clear_cost();
        req_first_state = 0; n_hold_pairs = 0; n_psw_sp_wr = 0;
        n_long_op = 0; n_flag_read = 0;
    endtask

    initial begin
        #4_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n, first_src;
        for (int i = 0; i < NSRC; i++) set_lvl(i, 3);
        m_flag = '0;
        @(negedge clk); @(negedge clk);
        #1;
        chk("R1 reset flags", pend_flags, 0);
        chk("R4 reset inj_valid", inj_valid, 0);
        chk("R9 reset vec_fetch", vec_fetch, 0);
        rst = 1'b0;
        idle(2);

        // R4: no penalty, no hold
        set_lvl(3, 5);
        latency(8'h08, 0, n);
        chk("R4 base latency", n, 3);
        idle(2);

        // R5: first-state flag adds one
        req_first_state = 1;
        latency(8'h08, 0, n);
        chk("R5 first-state latency", n, 4);
        clear_cost(); idle(2);

        // R5: both hold pairs plus status/stack write
        n_hold_pairs = 2'b11; n_psw_sp_wr = 1;
        latency(8'h01, 0, n);
        chk("R5 hold+write latency", n, 6);
        clear_cost(); idle(2);

        // R5: long op and flag read, two each
        n_long_op = 1; n_flag_read = 1;
        latency(8'h04, 0, n);
        chk("R5 long+flagread latency", n, 7);
        clear_cost(); idle(2);

        // R6: pipeline hold keeps the trap out of decode
        latency(8'h10, 4, n);
        chk("R6 hold latency", n, 5);
        idle(2);

        // R3: higher level wins
        set_lvl(2, 7); set_lvl(5, 9);
        irq_req = 8'h24; tick(); irq_req = '0;
        tick(); #1;
        chk("R3 higher level first", inj_src, 5);
        idle(8);
        chk("R3 both served", pend_flags, 0);

        // R3: tie goes to the lowest index
        set_lvl(1, 9); set_lvl(6, 9);
        irq_req = 8'h42; tick(); irq_req = '0;
        tick(); #1;
        first_src = int'(inj_src);
        chk("R3 tie lowest index", first_src, 1);
        idle(8);

        // R2: global enable off, then level equal to CPU level, then source disabled
        glb_ie = 0;
        irq_req = 8'h10; tick(); irq_req = '0;
        idle(6); #1;
        chk("R2 no fetch with gie off", vec_fetch, 0);
        chk("R2 flag kept with gie off", pend_flags[4], 1);
        glb_ie = 1; cpu_level = 4'd3;
        idle(6); #1;
        chk("R2 equal level blocked", pend_flags[4], 1);
        cpu_level = 4'd2; src_en[4] = 0;
        idle(6); #1;
        chk("R2 disabled source blocked", pend_flags[4], 1);
        src_en[4] = 1;
        idle(6);
        chk("R2 served when eligible", pend_flags[4], 0);
        cpu_level = 0;

        // R8: no segment push when segmented mode is off
        seg_mode = 0;
        latency(8'h80, 0, n);
        #1 chk("R8 no csp push", save_csp_strobe, 0);
        seg_mode = 1; idle(2);

        // R1: request on same source in its injection cycle keeps flag set
        set_lvl(6, 4);
        irq_req = 8'h40; tick(); irq_req = '0;
        tick();
        irq_req = 8'h40; tick(); irq_req = '0;
        #1 chk("R1 set beats clear", pend_flags[6], 1);
        idle(6);
        chk("R1 second service", pend_flags[6], 0);

        // R10: request from a higher source during a sequence waits its turn
        set_lvl(0, 2); set_lvl(7, 12);
        n_long_op = 1;
        irq_req = 8'h01; tick(); irq_req = '0;
        tick();
        irq_req = 8'h80; tick(); irq_req = '0;
        idle(3); #1;
        chk("R10 first winner kept", inj_src, 0);
        idle(12);
        chk("R10 all served", pend_flags, 0);
        clear_cost();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule